// File: doc/BRIEF.md
# Per-Operand Element-Width Integer Adder

This unit adds two integer elements for a vector-style extension in which the first source, the second source and the destination each carry their own 2-bit width code. A code is read against the configured base register width, which is 32 or 64 bits, and selects an element of 8, 16, 32 or 64 bits. For the plain forms, each source is cut to its own width and zero-extended to the destination width. The two are then added, and the sum is kept at the destination width.

Four operations are available. Two add a register and a register. Two add a register and a 12-bit immediate. The word forms ignore all width codes and always give a sign-extended 32-bit sum. A caller presents the operands, the codes, the immediate, the opcode and the base-width select with a one-cycle valid pulse. The registered result appears on the next clock.

Top module: `ew_adder`

## Requirements
- R1: Width code 2'b00 selects the base register width: 64 bits when `xlen64` is 1 and 32 bits when it is 0.
- R2: Width code 2'b01 selects 32 bits when `xlen64` is 1 and 64 bits when it is 0. The 64-bit case with a 32-bit base gives a full 64-bit sum.
- R3: Width code 2'b10 selects 16 bits and code 2'b11 selects 8 bits, whatever the base width.
- R4: For `op` 2'b00 (register add), each source is cut to the width of its own code, zero-extended and added.
- R5: For `op` 2'b01 (immediate add), the 12-bit immediate is sign-extended, or truncated, to the first source's width. It is then zero-extended and added.
- R6: For `op` 2'b00 and 2'b01, the sum is truncated to the destination width. All result bits above that width are 0.
- R7: For `op` 2'b10 (word register add) and 2'b11 (word immediate add), the low 32 bits of the first source are added to the low 32 bits of the second source or of the sign-extended immediate. The 32-bit sum is sign-extended from bit 31 to 64 bits, and all width codes have no effect.
- R8: Source bits above a source's selected width do not change the result.
- R9: `out_valid` is high exactly one cycle after each `in_valid` cycle. `out_result` changes only in that cycle and otherwise holds its value.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| op | input | 2 | 00 add, 01 add-immediate, 10 word add, 11 word add-immediate |
| xlen64 | input | 1 | Base register width: 1 for 64 bits, 0 for 32 bits |
| src1_wc | input | 2 | Width code of the first source |
| src2_wc | input | 2 | Width code of the second source |
| dst_wc | input | 2 | Width code of the destination |
| src1 | input | 64 | First source value |
| src2 | input | 64 | Second source value |
| imm | input | 12 | Signed immediate |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Registered result |

## Verification
Every result is due exactly one clock edge after its valid pulse, because one register stage lies between the inputs and the outputs. The bench drives inputs on the falling edge and samples `out_valid` and `out_result` at the next falling edge, half a cycle after the capturing rising edge. It then checks at the falling edge after that, and a few edges later, that the valid flag has dropped and the result is unchanged.

// File: rtl/ew_adder.sv
module ew_adder #(
  parameter int IMM_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic             xlen64,
  input  logic [1:0]       src1_wc,
  input  logic [1:0]       src2_wc,
  input  logic [1:0]       dst_wc,
  input  logic [63:0]      src1,
  input  logic [63:0]      src2,
  input  logic [IMM_W-1:0] imm,
  output logic             out_valid,
  output logic [63:0]      out_result
);
  localparam logic [63:0] LOW32 = 64'h0000_0000_FFFF_FFFF;

  function automatic logic [63:0] wmask(input logic [1:0] code, input logic x64);
    case (code)
      2'b00:   wmask = x64 ? '1 : LOW32;
      2'b01:   wmask = x64 ? LOW32 : '1;
      2'b10:   wmask = 64'hFFFF;
      default: wmask = 64'hFF;
    endcase
  endfunction

  logic [63:0] m1, m2, md, imm_x, opa, opb, nsum, wres, next_res;
  logic [31:0] wsum;

  assign m1    = wmask(src1_wc, xlen64);
  assign m2    = wmask(src2_wc, xlen64);
  assign md    = wmask(dst_wc, xlen64);
  assign imm_x = {{(64-IMM_W){imm[IMM_W-1]}}, imm};

  assign opa  = src1 & m1;
  assign opb  = op[0] ? (imm_x & m1) : (src2 & m2);
  assign nsum = (opa + opb) & md;

  assign wsum = src1[31:0] + (op[0] ? imm_x[31:0] : src2[31:0]);
  assign wres = {{32{wsum[31]}}, wsum};

  assign next_res = op[1] ? wres : nsum;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= next_res;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && out_result == '0)); // R10
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_result)); // R9
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(op[1]) && $past(dst_wc) == 2'b11) |-> out_result[63:8] == '0); // R6
  AST_WORD_SEXT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op[1])) |-> out_result[63:32] == {32{out_result[31]}}); // R7
endmodule

// File: tb/ew_adder_test.sv
`timescale 1ns/1ps
module ew_adder_test;
  logic clk = 1'b0;
  logic rst, in_valid, xlen64;
  logic [1:0] op, src1_wc, src2_wc, dst_wc;
  logic [63:0] src1, src2;
  logic [11:0] imm;
  logic out_valid;
  logic [63:0] out_result;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ew_adder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .xlen64(xlen64),
    .src1_wc(src1_wc), .src2_wc(src2_wc), .dst_wc(dst_wc),
    .src1(src1), .src2(src2), .imm(imm),
    .out_valid(out_valid), .out_result(out_result)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        x64;
    logic [1:0]  w1;
    logic [1:0]  w2;
    logic [1:0]  wd;
    logic [63:0] a;
    logic [63:0] b;
    logic [11:0] im;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT[NV] = '{
    '{2'd0, 1'b1, 2'b00, 2'b00, 2'b00, 64'h0000_0001_0000_0005, 64'h3, 12'h0, 64'h0000_0001_0000_0008, 8'd1},
    '{2'd0, 1'b0, 2'b00, 2'b00, 2'b00, 64'h0000_0001_FFFF_FFFF, 64'h1, 12'h0, 64'h0, 8'd1},
    '{2'd0, 1'b0, 2'b01, 2'b01, 2'b01, 64'hFFFF_FFFF_0000_0000, 64'h8000_0000, 12'h0, 64'hFFFF_FFFF_8000_0000, 8'd2},
    '{2'd0, 1'b1, 2'b01, 2'b01, 2'b01, 64'hAAAA_AAAA_7FFF_FFFF, 64'h5555_5555_0000_0001, 12'h0, 64'h8000_0000, 8'd8},
    '{2'd0, 1'b1, 2'b11, 2'b10, 2'b00, 64'h1FF, 64'h3_FFFF, 12'h0, 64'h1_00FE, 8'd4},
    '{2'd0, 1'b1, 2'b00, 2'b00, 2'b11, 64'hF0, 64'h20, 12'h0, 64'h10, 8'd6},
    '{2'd1, 1'b1, 2'b11, 2'b00, 2'b00, 64'h5, 64'h0, 12'hFFF, 64'h104, 8'd5},
    '{2'd1, 1'b1, 2'b00, 2'b00, 2'b00, 64'h5, 64'h0, 12'hFFF, 64'h4, 8'd5},
    '{2'd1, 1'b0, 2'b10, 2'b00, 2'b10, 64'h1, 64'h0, 12'h800, 64'hF801, 8'd5},
    '{2'd2, 1'b1, 2'b11, 2'b11, 2'b11, 64'h7FFF_FFFF, 64'h1, 12'h0, 64'hFFFF_FFFF_8000_0000, 8'd7},
    '{2'd3, 1'b0, 2'b10, 2'b10, 2'b10, 64'h1234_5678_0000_0010, 64'h0, 12'hFF0, 64'h0, 8'd7},
    '{2'd2, 1'b1, 2'b00, 2'b00, 2'b00, 64'hFFFF_FFFF_0000_0001, 64'h2, 12'h0, 64'h3, 8'd7},
    '{2'd0, 1'b0, 2'b01, 2'b11, 2'b10, 64'h1_0000_FFFF, 64'h102, 12'h0, 64'h1, 8'd3}
  };
  // Rows tag R1 R2 R3 R4 R5 R6 R7 R8 through the req field.

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    op = v.op; xlen64 = v.x64; src1_wc = v.w1; src2_wc = v.w2; dst_wc = v.wd;
    src1 = v.a; src2 = v.b; imm = v.im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rst = 1'b1; in_valid = 1'b0; op = '0; xlen64 = 1'b1;
    src1_wc = '0; src2_wc = '0; dst_wc = '0; src1 = '0; src2 = '0; imm = '0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset result", out_result, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      check($sformatf("R9 valid row %0d", i), {63'd0, out_valid}, 64'd1);
      check($sformatf("R%0d row %0d", VT[i].req, i), out_result, VT[i].exp);
    end

    // R9: pulse ends and the result holds
    held = out_result;
    @(negedge clk);
    check("R9 valid drops", {63'd0, out_valid}, 64'd0);
    src1 = 64'hFFFF; src2 = 64'h1234; op = 2'd0;
    repeat (3) @(negedge clk);
    check("R9 result held", out_result, held);

    // R8: garbage above 16 bits is ignored
    drive('{2'd0, 1'b1, 2'b10, 2'b10, 2'b00, 64'hDEAD_BEEF_0000_0003, 64'hFFFF_0000_0001_0004, 12'h0, 64'h7, 8'd8});
    check("R8 upper bits ignored", out_result, 64'h7);

    // R2: 32-bit base with 64-bit codes gives a carry into the upper word
    drive('{2'd0, 1'b0, 2'b01, 2'b01, 2'b01, 64'hFFFF_FFFF, 64'h1, 12'h0, 64'h1_0000_0000, 8'd2});
    check("R2 full 64-bit sum", out_result, 64'h1_0000_0000);

    // R7: the word forms ignore the width codes
    drive('{2'd3, 1'b1, 2'b11, 2'b11, 2'b11, 64'h0000_0000_7FFF_FF00, 64'h0, 12'h7FF, 64'hFFFF_FFFF_8000_06FF, 8'd7});
    check("R7 word imm ignores codes", out_result, 64'hFFFF_FFFF_8000_06FF);

    // R10: reset clears a live result
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 mid reset result", out_result, 64'd0);
    check("R10 mid reset valid", {63'd0, out_valid}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule